// File: doc/BRIEF.md
# Single-Step Word Shifter with Serial Fill

This block moves an n-bit word by one bit position toward the most significant or the least significant end, or passes it unchanged, using purely combinational logic. The result is available in the same cycle the operands arrive. It needs no separate load, shift and store clock steps.

A two-bit mode input selects the operation. Two serial fill inputs supply the bit that enters the vacated end: one for right shifts and one for left shifts. Two serial spill outputs always show the bit that each direction would push out. Because of this, several instances can be chained into a wider shifter, or fed from a serial stream. Each result bit is picked by its own three-way multiplexer, and all of these multiplexers share the mode select.

Top module: `step_shifter`

## Requirements
- R1: With mode = 0, word_out equals word_in.
- R2: With mode = 1 (right shift), word_out[i] = word_in[i+1] for i < W-1, and word_out[W-1] = rfill.
- R3: With mode = 2 (left shift), word_out[i] = word_in[i-1] for i > 0, and word_out[0] = lfill.
- R4: With mode = 3, word_out is all zeros, whatever word_in and the fill inputs are.
- R5: rspill always equals word_in[0], in every mode.
- R6: lspill always equals word_in[W-1], in every mode.
- R7: Every output settles combinationally after an input change, with no clock edge needed.
- R8: A fill input that the current mode does not use has no effect on word_out. This covers lfill in modes 0, 1 and 3, and rfill in modes 0, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_in | input | W | Word to be shifted |
| mode | input | 2 | 0 pass, 1 right, 2 left, 3 clear |
| rfill | input | 1 | Bit entering the MSB on a right shift |
| lfill | input | 1 | Bit entering the LSB on a left shift |
| word_out | output | W | Shifted result |
| rspill | output | 1 | Bit leaving the LSB end (word_in[0]) |
| lspill | output | 1 | Bit leaving the MSB end (word_in[W-1]) |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register sits between any input and any output. The bench applies a new input set just after a rising clock edge. It samples 1 ns later, well before the next edge, and no clock edge falls between stimulus and check. This sampling point demonstrates R7. For each mode, it then sweeps every input word and both fill values and compares the outputs against values derived from the requirements.

// File: rtl/step_shifter.sv
module step_shifter #(
  parameter int W = 4
) (
  input  logic [W-1:0] word_in,
  input  logic [1:0]   mode,
  input  logic         rfill,
  input  logic         lfill,
  output logic [W-1:0] word_out,
  output logic         rspill,
  output logic         lspill
);
  localparam logic [1:0] M_PASS  = 2'd0;
  localparam logic [1:0] M_RIGHT = 2'd1;
  localparam logic [1:0] M_LEFT  = 2'd2;

  logic [W+1:0] ext;
  assign ext = {rfill, word_in, lfill};

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (mode)
        M_PASS:  word_out[i] = ext[i+1];
        M_RIGHT: word_out[i] = ext[i+2];
        M_LEFT:  word_out[i] = ext[i];
        default: word_out[i] = 1'b0;
      endcase
    end
  end

  assign rspill = word_in[0];
  assign lspill = word_in[W-1];

  always_comb begin
    if (mode == M_PASS)
      p_pass_r1: assert (word_out == word_in);
    if (mode == M_RIGHT)
      p_rfill_r2: assert (word_out[W-1] == rfill && word_out[W-2:0] == word_in[W-1:1]);
    if (mode == M_LEFT)
      p_lfill_r3: assert (word_out[0] == lfill && word_out[W-1:1] == word_in[W-2:0]);
    if (mode == 2'd3)
      p_clear_r4: assert (word_out == '0);
  end
endmodule

// File: tb/tb_step_shifter.sv
module tb_step_shifter;
  localparam int W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] word_in = '0;
  logic [1:0]   mode = 2'd0;
  logic         rfill = 1'b0, lfill = 1'b0;
  logic [W-1:0] word_out;
  logic         rspill, lspill;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  step_shifter #(.W(W)) dut (
    .word_in(word_in), .mode(mode), .rfill(rfill), .lfill(lfill),
    .word_out(word_out), .rspill(rspill), .lspill(lspill)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: w=%b m=%0d rf=%b lf=%b act=%b exp=%b",
               req, word_in, mode, rfill, lfill, act, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] w, logic [1:0] m, logic rf, logic lf);
    @(posedge clk);
    word_in = w; mode = m; rfill = rf; lfill = lf;
    #1;
  endtask

  task automatic t_idle;
    apply('0, 2'd0, 1'b0, 1'b0);
    chk("R1 idle out", word_out, '0);
    chk("R5 idle rspill", W'(rspill), '0);
    chk("R6 idle lspill", W'(lspill), '0);
  endtask

  task automatic t_mode(logic [1:0] m);
    for (int w = 0; w < (1 << W); w++)
      for (int f = 0; f < 4; f++) begin
        logic [W-1:0] wv, e;
        logic rf, lf;
        wv = W'(w); rf = f[1]; lf = f[0];
        apply(wv, m, rf, lf);
        case (m)
          2'd0: e = wv;
          2'd1: e = {rf, wv[W-1:1]};
          2'd2: e = {wv[W-2:0], lf};
          default: e = '0;
        endcase
        case (m)
          2'd0: chk("R1/R8 pass", word_out, e);
          2'd1: chk("R2/R8 right", word_out, e);
          2'd2: chk("R3/R8 left", word_out, e);
          default: chk("R4/R8 clear", word_out, e);
        endcase
        chk("R5 rspill", W'(rspill), W'(wv[0]));
        chk("R6 lspill", W'(lspill), W'(wv[W-1]));
      end
  endtask

  task automatic t_settle;
    apply(4'b1011, 2'd1, 1'b0, 1'b0);
    word_in = 4'b0110; mode = 2'd2; lfill = 1'b1;
    #1;
    chk("R7 no edge left", word_out, 4'b1101);
    mode = 2'd3;
    #0.5;
    chk("R7 no edge clear", word_out, 4'b0000);
  endtask

  task automatic t_unused_fill;
    apply(4'b1001, 2'd1, 1'b1, 1'b0);
    chk("R8 right lfill0", word_out, 4'b1100);
    lfill = 1'b1; #1;
    chk("R8 right lfill1", word_out, 4'b1100);
    apply(4'b1001, 2'd2, 1'b0, 1'b0);
    chk("R8 left rfill0", word_out, 4'b0010);
    rfill = 1'b1; #1;
    chk("R8 left rfill1", word_out, 4'b0010);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_mode(2'd0);
    t_mode(2'd1);
    t_mode(2'd2);
    t_mode(2'd3);
    t_settle();
    t_unused_fill();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule